// File: doc/BRIEF.md
# Grouped Interrupt Expander

This block gathers a wide set of peripheral interrupt sources into a small number of CPU request lines. The sources are split into groups, and each group drives one CPU line. When a source fires, its flag is latched. Software enables each source separately. A group raises its CPU line only while some source in it is both flagged and enabled, and only while the group's handshake latch is open.

When the group forwards a request, it closes its own latch. The group then stays silent until software reopens the latch by writing a 1 to it. This lets the CPU handle one request per group at a time. The CPU can ask for the vector of a group. The block returns the flat index of the highest-priority source that is flagged and enabled in that group, and clears that source's flag.

Software reaches the flags, the enables and the group latches through a small register port. Reads are registered.

Top module: `irqx_expander`

## Requirements
- R1: A one-cycle high on `src_evt[g*8+s]` sets bit s of group g's flag register at the next clock edge. The bit stays set after the event input drops, until it is cleared by R7 or by an R11 write.
- R2: Group g forwards when the AND of its flags and enables is non-zero and its latch is 0. At that clock edge `cpu_irq[g]` becomes 1 for exactly one cycle and the latch becomes 1. The latch then reads back as bit g of the latch register.
- R3: While group g's latch is 1, `cpu_irq[g]` stays 0, whatever new events arrive in the group.
- R4: Writing 1 to bit g of the latch register clears group g's latch. Writing 0 leaves it unchanged. If the group still has a flagged and enabled source, it forwards again at the edge after the clear.
- R5: Within a group, the lowest-numbered active bit wins. Bit 0 has the highest priority and bit 7 the lowest.
- R6: A `vec_req` for group `vec_grp` makes `vec_valid` 1 and `vec_idx` = `vec_grp`*8 + winning bit on the next cycle. If the group has no flagged and enabled source, or `vec_grp` is 12 or more, then `vec_valid` is 0 and `vec_idx` is 0.
- R7: A granted vector request clears only the winning source's flag. The other flags of the group stay latched.
- R8: A flag whose enable is 0 stays latched and raises no request. Once the enable is written to 1, the group forwards.
- R9: After reset, all flags, enables and latches are 0, and `cpu_irq`, `vec_valid`, `vec_idx` and `reg_rdata` are all 0.
- R10: When a new event on a source coincides with a clear of that source's flag, the flag stays set. This holds whether the clear comes from a vector request or from a flag write.
- R11: Register port selection by `reg_kind`:
  - kind 0: enable register of group `reg_grp`, read/write, low 8 bits.
  - kind 1: flag register of group `reg_grp`. Reads return the flags; writing 1 to a bit clears that flag.
  - kind 2: latch register, bit g for group g. Writing 1 to a bit clears that latch.
  - kind 3: reads 0.
  
  `reg_rdata` shows the selected register one cycle after selection. A group number of 12 or more reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_evt | input | 96 | Source events, bit g*8+s is source s of group g |
| reg_we | input | 1 | Register write strobe |
| reg_kind | input | 2 | Register kind: 0 enable, 1 flag, 2 latch, 3 none |
| reg_grp | input | 4 | Group selected by the register port |
| reg_wdata | input | 12 | Register write data |
| reg_rdata | output | 12 | Registered read data |
| vec_req | input | 1 | Vector fetch request |
| vec_grp | input | 4 | Group whose vector is fetched |
| vec_valid | output | 1 | Vector result valid |
| vec_idx | output | 7 | Flat index of the winning source |
| cpu_irq | output | 12 | One-cycle request pulse per group |

## Verification
A new source event can land in the same cycle as a clear of that same flag. The clear may come from a vector fetch of the winning source or from a write-1 to the flag register. The bench provokes both collisions on purpose.

It then reads the flag back and expects it to still be set. During a long random phase, events, fetches, flag writes and latch writes all fall on arbitrary cycles. A bench-side model, built from the requirements, predicts `cpu_irq`, the vector and the read data on every cycle.

// File: rtl/irqx_pkg.sv
package irqx_pkg;

  typedef enum logic [1:0] {
    RK_ENABLE = 2'd0,
    RK_FLAG   = 2'd1,
    RK_LATCH  = 2'd2,
    RK_NONE   = 2'd3
  } reg_kind_e;

endpackage

// File: rtl/irqx_prio.sv
// Fixed-priority picker: the lowest set bit wins.
module irqx_prio #(
  parameter  int W  = 8,
  localparam int SW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  req,
  output logic          any,
  output logic [SW-1:0] idx,
  output logic [W-1:0]  onehot
);

  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) idx = SW'(i);
    end
    any    = |req;
    onehot = {{(W-1){1'b0}}, any} << idx;
  end

  // Grant must point at a requesting bit with nothing of higher priority below it.
  always_comb begin
    if (any) begin
      assert_grant_lowest_R5: assert (req[idx] && ((req & (onehot - W'(1))) == '0))
        else $error("priority grant is not the lowest active bit");
    end
  end

endmodule

// File: rtl/irqx_group.sv
// One group: latched flags, enables, handshake latch and forward pulse.
module irqx_group #(
  parameter  int NS = 8,
  localparam int SW = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NS-1:0] evt,
  input  logic          en_we,
  input  logic [NS-1:0] en_wdata,
  input  logic          clr_we,
  input  logic [NS-1:0] clr_mask,
  input  logic          ack_clr,
  input  logic          fetch,
  output logic [NS-1:0] flags,
  output logic [NS-1:0] enables,
  output logic          ack,
  output logic          irq,
  output logic          win_any,
  output logic [SW-1:0] win_idx
);

  logic [NS-1:0] active;
  logic [NS-1:0] win_oh;
  logic [NS-1:0] drop;
  logic          fire;

  assign active = flags & enables;

  irqx_prio #(.W(NS)) u_prio (
    .req    (active),
    .any    (win_any),
    .idx    (win_idx),
    .onehot (win_oh)
  );

  assign fire = win_any && !ack;

  always_comb begin
    drop = '0;
    if (fetch)  drop = drop | win_oh;
    if (clr_we) drop = drop | clr_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags   <= '0;
      enables <= '0;
      ack     <= 1'b0;
      irq     <= 1'b0;
    end else begin
      flags <= (flags & ~drop) | evt;   // a fresh event beats any clear
      if (en_we) enables <= en_wdata;
      ack <= fire | (ack & ~ack_clr);
      irq <= fire;
    end
  end

  // Without any clear source active, no latched flag may drop.
  assert_flags_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (!fetch && !clr_we) |=> ((flags & $past(flags)) == $past(flags)))
    else $error("flag dropped without a clear");

  // A forward needs an active source in the previous cycle.
  assert_irq_needs_active_R2: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(win_any))
    else $error("request forwarded with no active source");

  // The latch closes on a forward, so no back-to-back pulses.
  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq)
    else $error("group forwarded twice in a row");

  // A closed latch stays closed until software writes 1.
  assert_latch_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (ack && !ack_clr) |=> ack)
    else $error("latch opened without a write");

endmodule

// File: rtl/irqx_expander.sv
module irqx_expander
  import irqx_pkg::*;
#(
  parameter  int NG    = 12,
  parameter  int NS    = 8,
  localparam int GRP_W = $clog2(NG),
  localparam int SEL_W = (NS > 1) ? $clog2(NS) : 1,
  localparam int VEC_W = $clog2(NG * NS),
  localparam int REG_W = (NG > NS) ? NG : NS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NG*NS-1:0] src_evt,
  input  logic             reg_we,
  input  logic [1:0]       reg_kind,
  input  logic [GRP_W-1:0] reg_grp,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             vec_req,
  input  logic [GRP_W-1:0] vec_grp,
  output logic             vec_valid,
  output logic [VEC_W-1:0] vec_idx,
  output logic [NG-1:0]    cpu_irq
);

  reg_kind_e        kind;
  logic [NS-1:0]    flags   [NG];
  logic [NS-1:0]    enables [NG];
  logic [SEL_W-1:0] win_idx [NG];
  logic [NG-1:0]    win_any;
  logic [NG-1:0]    ack;

  logic             sel_hit;
  logic [SEL_W-1:0] sel_idx;
  logic [NS-1:0]    rd_flags;
  logic [NS-1:0]    rd_en;

  assign kind = reg_kind_e'(reg_kind);

  for (genvar g = 0; g < NG; g++) begin : g_grp
    irqx_group #(.NS(NS)) u_grp (
      .clk      (clk),
      .rst      (rst),
      .evt      (src_evt[g*NS +: NS]),
      .en_we    (reg_we && kind == RK_ENABLE && reg_grp == GRP_W'(g)),
      .en_wdata (reg_wdata[NS-1:0]),
      .clr_we   (reg_we && kind == RK_FLAG && reg_grp == GRP_W'(g)),
      .clr_mask (reg_wdata[NS-1:0]),
      .ack_clr  (reg_we && kind == RK_LATCH && reg_wdata[g]),
      .fetch    (vec_req && vec_grp == GRP_W'(g)),
      .flags    (flags[g]),
      .enables  (enables[g]),
      .ack      (ack[g]),
      .irq      (cpu_irq[g]),
      .win_any  (win_any[g]),
      .win_idx  (win_idx[g])
    );
  end

  // Group selection for the vector fetch and the register read.
  always_comb begin
    sel_hit  = 1'b0;
    sel_idx  = '0;
    rd_flags = '0;
    rd_en    = '0;
    for (int g = 0; g < NG; g++) begin
      if (vec_grp == GRP_W'(g)) begin
        sel_hit = win_any[g];
        sel_idx = win_idx[g];
      end
      if (reg_grp == GRP_W'(g)) begin
        rd_flags = flags[g];
        rd_en    = enables[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_valid <= 1'b0;
      vec_idx   <= '0;
    end else begin
      vec_valid <= vec_req && sel_hit;
      vec_idx   <= (vec_req && sel_hit)
                   ? VEC_W'(vec_grp) * VEC_W'(NS) + VEC_W'(sel_idx)
                   : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      unique case (kind)
        RK_ENABLE: reg_rdata <= REG_W'(rd_en);
        RK_FLAG:   reg_rdata <= REG_W'(rd_flags);
        RK_LATCH:  reg_rdata <= REG_W'(ack);
        default:   reg_rdata <= '0;
      endcase
    end
  end

  assert_vec_in_range_R6: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> (int'(vec_idx) < NG * NS))
    else $error("vector index out of range");

  assert_vec_after_req_R6: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> $past(vec_req))
    else $error("vector valid without a request");

  assert_idle_vec_zero_R6: assert property (@(posedge clk) disable iff (rst)
    !vec_valid |-> (vec_idx == '0))
    else $error("vector index not zero when invalid");

endmodule

// File: tb/irqx_expander_tb.sv
module irqx_expander_tb;
  localparam int NG = 12;
  localparam int NS = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic [95:0]   src_evt;
  logic          reg_we;
  logic [1:0]    reg_kind;
  logic [3:0]    reg_grp;
  logic [11:0]   reg_wdata;
  logic [11:0]   reg_rdata;
  logic          vec_req;
  logic [3:0]    vec_grp;
  logic          vec_valid;
  logic [6:0]    vec_idx;
  logic [11:0]   cpu_irq;

  always #4 clk = ~clk;

  irqx_expander u_dut (
    .clk(clk), .rst(rst), .src_evt(src_evt), .reg_we(reg_we), .reg_kind(reg_kind),
    .reg_grp(reg_grp), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .vec_req(vec_req),
    .vec_grp(vec_grp), .vec_valid(vec_valid), .vec_idx(vec_idx), .cpu_irq(cpu_irq)
  );

  int checks = 0;
  int errors = 0;

  // Reference state built from the requirements.
  logic [7:0]  m_flag [NG];
  logic [7:0]  m_en   [NG];
  logic [11:0] m_ack, m_irq, m_rd;
  logic        m_vv;
  logic [6:0]  m_vidx;
  logic [11:0] rv;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int lowest(logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic step();
    logic [7:0]  n_flag [NG];
    logic [7:0]  n_en   [NG];
    logic [11:0] n_ack, n_irq, n_rd;
    logic        n_vv;
    logic [6:0]  n_vidx;
    logic [7:0]  act, clr;
    n_vv = 1'b0; n_vidx = '0; n_rd = '0;
    for (int g = 0; g < NG; g++) begin
      act = m_flag[g] & m_en[g];
      clr = '0;
      if (vec_req && vec_grp == g && act != 0) begin
        clr[lowest(act)] = 1'b1;
        n_vv = 1'b1;
        n_vidx = 7'(g * 8 + lowest(act));
      end
      if (reg_we && reg_kind == 2'd1 && reg_grp == g) clr = clr | reg_wdata[7:0];
      n_flag[g] = (m_flag[g] & ~clr) | src_evt[g*8 +: 8];
      n_en[g]   = (reg_we && reg_kind == 2'd0 && reg_grp == g) ? reg_wdata[7:0] : m_en[g];
      n_irq[g]  = (act != 0) && !m_ack[g];
      n_ack[g]  = n_irq[g] ? 1'b1 : ((reg_we && reg_kind == 2'd2 && reg_wdata[g]) ? 1'b0 : m_ack[g]);
      if (reg_grp == g && reg_kind == 2'd0) n_rd = {4'h0, m_en[g]};
      if (reg_grp == g && reg_kind == 2'd1) n_rd = {4'h0, m_flag[g]};
    end
    if (reg_kind == 2'd2) n_rd = m_ack;
    @(posedge clk);
    for (int g = 0; g < NG; g++) begin
      m_flag[g] = n_flag[g];
      m_en[g]   = n_en[g];
    end
    m_ack = n_ack; m_irq = n_irq; m_vv = n_vv; m_vidx = n_vidx; m_rd = n_rd;
    @(negedge clk);
    chk("R2", "cpu_irq", cpu_irq, m_irq);
    chk("R6", "vec_valid", vec_valid, m_vv);
    chk("R6", "vec_idx", vec_idx, m_vidx);
    chk("R11", "reg_rdata", reg_rdata, m_rd);
    src_evt = '0; reg_we = 1'b0; vec_req = 1'b0;
  endtask

  task automatic rd(logic [1:0] k, logic [3:0] g, output logic [11:0] v);
    reg_kind = k; reg_grp = g;
    step();
    v = reg_rdata;
  endtask

  task automatic wr(logic [1:0] k, logic [3:0] g, logic [11:0] d);
    reg_we = 1'b1; reg_kind = k; reg_grp = g; reg_wdata = d;
    step();
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; src_evt = '0; reg_we = 1'b0; reg_kind = '0; reg_grp = '0;
    reg_wdata = '0; vec_req = 1'b0; vec_grp = '0;
    for (int g = 0; g < NG; g++) begin m_flag[g] = '0; m_en[g] = '0; end
    m_ack = '0; m_irq = '0; m_rd = '0; m_vv = 1'b0; m_vidx = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    chk("R9", "cpu_irq", cpu_irq, 0);
    chk("R9", "vec_valid", vec_valid, 0);
    chk("R9", "reg_rdata", reg_rdata, 0);
    rd(2'd2, 4'd0, rv); chk("R9", "latch reg", rv, 0);

    // R1 / R8: disabled source latches and stays quiet
    src_evt[2*8+5] = 1'b1; step();
    repeat (3) step();
    rd(2'd1, 4'd2, rv); chk("R1", "flag g2", rv, 12'h020);
    chk("R8", "no irq while disabled", cpu_irq, 0);
    wr(2'd0, 4'd2, 12'h0FF);
    step(); chk("R8", "irq after enable", cpu_irq, 12'h004);
    step(); chk("R2", "one-cycle pulse", cpu_irq, 0);

    // R3: latch closed blocks new events
    src_evt[2*8+1] = 1'b1; step();
    repeat (3) step();
    chk("R3", "blocked irq", cpu_irq, 0);
    rd(2'd2, 4'd0, rv); chk("R2", "latch set", rv, 12'h004);

    // R5 / R6 / R7: vector fetch
    vec_req = 1'b1; vec_grp = 4'd2; step();
    chk("R5", "winner idx", vec_idx, 17);
    chk("R6", "vec valid", vec_valid, 1);
    rd(2'd1, 4'd2, rv); chk("R7", "only winner cleared", rv, 12'h020);

    // R4: write-0 no effect, write-1 reopens and refires
    wr(2'd2, 4'd0, 12'hFFB);
    rd(2'd2, 4'd0, rv); chk("R4", "write 0 keeps latch", rv, 12'h004);
    wr(2'd2, 4'd0, 12'h004);
    step(); chk("R4", "refire after clear", cpu_irq, 12'h004);

    // R10: set beats clear in the same cycle
    vec_req = 1'b1; vec_grp = 4'd2; src_evt[2*8+5] = 1'b1; step();
    chk("R6", "vec idx g2s5", vec_idx, 21);
    rd(2'd1, 4'd2, rv); chk("R10", "event beats fetch clear", rv, 12'h020);
    src_evt[2*8+5] = 1'b1; wr(2'd1, 4'd2, 12'h020);
    rd(2'd1, 4'd2, rv); chk("R10", "event beats W1C", rv, 12'h020);
    wr(2'd1, 4'd2, 12'h020);
    rd(2'd1, 4'd2, rv); chk("R11", "W1C clears flag", rv, 0);

    // R6: empty group and top boundary
    vec_req = 1'b1; vec_grp = 4'd7; step();
    chk("R6", "empty group invalid", vec_valid, 0);
    vec_req = 1'b1; vec_grp = 4'd14; step();
    chk("R6", "out-of-range group invalid", vec_valid, 0);
    wr(2'd0, 4'd11, 12'h080);
    src_evt[95] = 1'b1; step();
    step(); chk("R2", "group 11 irq", cpu_irq, 12'h800);
    vec_req = 1'b1; vec_grp = 4'd11; step();
    chk("R6", "last source idx", vec_idx, 95);
    rd(2'd1, 4'd13, rv); chk("R11", "out-of-range read", rv, 0);
    rd(2'd3, 4'd0, rv); chk("R11", "kind 3 read", rv, 0);

    // Random phase, checked every cycle against the model (R1..R11)
    for (int n = 0; n < 4000; n++) begin
      for (int k = 0; k < 2; k++)
        if ($urandom % 3 == 0) src_evt[$urandom % 96] = 1'b1;
      if ($urandom % 6 == 0) begin
        reg_we = 1'b1; reg_wdata = 12'($urandom);
      end
      reg_kind = 2'($urandom % 4);
      reg_grp  = 4'($urandom % 14);
      if ($urandom % 3 == 0) begin
        vec_req = 1'b1; vec_grp = 4'($urandom % 13);
      end
      step();
    end

    summary();
    $finish;
  end
endmodule